// File: doc/BRIEF.md
# FIFO Read Unit Engine

The engine carries out one read instruction at a time on behalf of a dispatcher. An instruction names one of several external FIFO interfaces and a word count. The engine first asks that FIFO interface for a connection and holds the request until it is granted. It then pulls the requested number of words one at a time. Each word is handed out after a fixed, parameterised retrieval delay. After the last word it signals completion to the dispatcher and, in the same cycle, releases the connection toward the FIFO interface.

The engine stalls at three points. It waits in idle while no instruction is offered, waits for the connection grant, and waits during each pull until the FIFO interface offers data. Every output is a registered-state decode. Inputs never reach outputs through logic alone.

Top module: `read_unit_engine`

## Requirements
- R1: After reset the engine is idle: `instr_ready` is 1 and `conn_req`, `pull_req`, `rel`, `out_valid` and `done` are all 0.
- R2: An instruction is taken in a cycle where `instr_valid` and `instr_ready` are both 1. `instr_ready` stays 0 from the next cycle through the cycle of `done`, and returns to 1 in the cycle after `done`. An instruction offered while `instr_ready` is 0 is not taken.
- R3: From the cycle after acceptance, bit `instr_fifo` of `conn_req` (bit index = FIFO number) is the only bit set, and it is held until `conn_gnt` on that same bit is 1. Grants on any other bit, or given outside the request phase, have no effect.
- R4: In the cycle after the grant, `conn_req` drops. If the budget is nonzero, the bit of `pull_req` for the selected FIFO rises and is held until `pull_valid` on that bit is 1. `pull_valid` on any other bit is ignored.
- R5: The word on the selected lane of `pull_data` (FIFO k occupies bits k*DATA_W upward) in the pull handshake cycle appears on `out_data`, with `out_valid` set for exactly one cycle. This happens exactly RET_DELAY+1 cycles after the handshake cycle.
- R6: The budget field gives the number of words. After each `out_valid` other than the last, `pull_req` for the same FIFO rises in the next cycle. The words leave in pull order.
- R7: `done` and the bit of `rel` for the selected FIFO are one-cycle pulses. For a nonzero budget they fall in the same cycle as the last `out_valid`.
- R8: With a budget of 0, `done` and `rel` pulse in the cycle after the grant, with no `pull_req` and no `out_valid` at any point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Read instruction offered |
| instr_ready | output | 1 | Engine idle and able to take an instruction |
| instr_fifo | input | SEL_W | FIFO number named by the instruction |
| instr_budget | input | CNT_W | Number of words to read |
| conn_req | output | N_FIFO | Connection request, one bit per FIFO |
| conn_gnt | input | N_FIFO | Connection grant, one bit per FIFO |
| pull_req | output | N_FIFO | Pull request, one bit per FIFO |
| pull_valid | input | N_FIFO | Pull data offered, one bit per FIFO |
| pull_data | input | N_FIFO*DATA_W | Pull data lanes, FIFO k at bits k*DATA_W |
| rel | output | N_FIFO | Release pulse toward the FIFO interface |
| out_valid | output | 1 | Retrieved word valid |
| out_data | output | DATA_W | Retrieved word |
| done | output | 1 | Completion pulse toward the dispatcher |

## Verification
The last retrieved word, the completion pulse and the release pulse share one cycle. In the same cycle the dispatcher is usually already offering its next instruction. The bench drives instructions back to back, keeping `instr_valid` high while the engine is busy. It uses budgets of zero, one and several words, with varied grant and pull latencies and stray grants and data on unselected lanes. A behavioural model predicts every output in every cycle. It flags any cycle where `done`, `rel` and the final `out_valid` come apart, and any early acceptance of the waiting instruction.

// File: rtl/read_unit_engine.sv
module read_unit_engine #(
  parameter int N_FIFO    = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 4,
  parameter int RET_DELAY = 3,
  localparam int SEL_W    = (N_FIFO > 1) ? $clog2(N_FIFO) : 1,
  localparam int DLY_W    = (RET_DELAY > 0) ? $clog2(RET_DELAY + 1) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  output logic                     instr_ready,
  input  logic [SEL_W-1:0]         instr_fifo,
  input  logic [CNT_W-1:0]         instr_budget,
  output logic [N_FIFO-1:0]        conn_req,
  input  logic [N_FIFO-1:0]        conn_gnt,
  output logic [N_FIFO-1:0]        pull_req,
  input  logic [N_FIFO-1:0]        pull_valid,
  input  logic [N_FIFO*DATA_W-1:0] pull_data,
  output logic [N_FIFO-1:0]        rel,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     done
);

  typedef enum logic [2:0] {S_IDLE, S_CONN, S_PULL, S_WAIT, S_EMIT, S_REL} st_t;

  st_t               st, st_nx;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  left;
  logic [DLY_W-1:0]  wcnt;
  logic [DATA_W-1:0] word;

  logic [N_FIFO-1:0] sel_bit;
  logic              gnt_sel, pv_sel, last;

  assign sel_bit = {{(N_FIFO-1){1'b0}}, 1'b1} << sel;
  assign gnt_sel = conn_gnt[sel];
  assign pv_sel  = pull_valid[sel];
  assign last    = (left == CNT_W'(1));

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (instr_valid) st_nx = S_CONN;
      S_CONN: if (gnt_sel) st_nx = (left == '0) ? S_REL : S_PULL;
      S_PULL: if (pv_sel) st_nx = (RET_DELAY == 0) ? S_EMIT : S_WAIT;
      S_WAIT: if (wcnt == '0) st_nx = S_EMIT;
      S_EMIT: st_nx = last ? S_IDLE : S_PULL;
      S_REL:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sel  <= '0;
      left <= '0;
      wcnt <= '0;
      word <= '0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && instr_valid) begin
        sel  <= instr_fifo;
        left <= instr_budget;
      end
      if (st == S_PULL && pv_sel) begin
        word <= pull_data[sel*DATA_W +: DATA_W];
        wcnt <= DLY_W'((RET_DELAY > 0) ? RET_DELAY - 1 : 0);
      end
      if (st == S_WAIT && wcnt != '0) wcnt <= wcnt - DLY_W'(1);
      if (st == S_EMIT) left <= left - CNT_W'(1);
    end
  end

  assign instr_ready = (st == S_IDLE);
  assign conn_req    = (st == S_CONN) ? sel_bit : '0;
  assign pull_req    = (st == S_PULL) ? sel_bit : '0;
  assign out_valid   = (st == S_EMIT);
  assign out_data    = word;
  assign done        = (st == S_REL) || (st == S_EMIT && last);
  assign rel         = done ? sel_bit : '0;

  // R3
  conn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(conn_req));

  // R3
  conn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|conn_req && !(|(conn_req & conn_gnt))) |=> $stable(conn_req));

  // R4
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pull_req && !(|(pull_req & pull_valid))) |=> $stable(pull_req));

  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|conn_req && |pull_req));

  // R7
  done_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(rel) == 1));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> instr_ready);

  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|conn_req || |pull_req || out_valid) |-> !instr_ready);

  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: tb/tb_read_unit_engine.sv
module tb_read_unit_engine;
  localparam int N = 4, DW = 32, CW = 4, D = 3, SW = 2;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0;
  logic [SW-1:0] instr_fifo = '0;
  logic [CW-1:0] instr_budget = '0;
  logic [N-1:0] conn_gnt = '0, pull_valid = '0;
  logic [N*DW-1:0] pull_data = '0;
  logic instr_ready, out_valid, done;
  logic [N-1:0] conn_req, pull_req, rel;
  logic [DW-1:0] out_data;

  read_unit_engine #(.N_FIFO(N), .DATA_W(DW), .CNT_W(CW), .RET_DELAY(D)) dut (
    .clk, .rst_n, .instr_valid, .instr_ready, .instr_fifo, .instr_budget,
    .conn_req, .conn_gnt, .pull_req, .pull_valid, .pull_data, .rel,
    .out_valid, .out_data, .done);

  always #2 clk = ~clk;

  int vecs = 0, errs = 0, cyc = 0;
  int glat = 0, plat = 0, noise = 0;
  int gcnt [N], pcnt [N], widx [N];

  int m_ph = 0, m_sel = 0, m_left = 0, m_w = 0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_ph = 0;
    else case (m_ph)
      0: if (instr_valid) begin m_sel = int'(instr_fifo); m_left = int'(instr_budget); m_ph = 1; end
      1: if (conn_gnt[m_sel]) m_ph = (m_left == 0) ? 5 : 2;
      2: if (pull_valid[m_sel]) begin
           m_data = pull_data[m_sel*DW +: DW]; m_w = D; m_ph = (D == 0) ? 4 : 3;
         end
      3: begin m_w--; if (m_w == 0) m_ph = 4; end
      4: begin m_left--; m_ph = (m_left == 0) ? 0 : 2; end
      default: m_ph = 0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [N-1:0] one;
    bit e_done;
    one = N'(1) << m_sel;
    e_done = (m_ph == 5) || (m_ph == 4 && m_left == 1);
    chk(instr_ready == (m_ph == 0), "R2", "instr_ready", 64'(instr_ready), 64'(m_ph == 0));
    chk(conn_req == ((m_ph == 1) ? one : '0), "R3", "conn_req", 64'(conn_req), 64'((m_ph == 1) ? one : '0));
    chk(pull_req == ((m_ph == 2) ? one : '0), "R4", "pull_req", 64'(pull_req), 64'((m_ph == 2) ? one : '0));
    chk(out_valid == (m_ph == 4), "R5", "out_valid", 64'(out_valid), 64'(m_ph == 4));
    if (m_ph == 4) chk(out_data == m_data, "R6", "out_data", 64'(out_data), 64'(m_data));
    chk(done == e_done, (m_ph == 5) ? "R8" : "R7", "done", 64'(done), 64'(e_done));
    chk(rel == (e_done ? one : '0), "R7", "rel", 64'(rel), 64'(e_done ? one : '0));
    for (int i = 0; i < N; i++) begin
      if (conn_req[i]) begin
        conn_gnt[i] = (gcnt[i] >= glat); gcnt[i]++;
      end else begin
        gcnt[i] = 0; conn_gnt[i] = (noise != 0) && cyc[0];
      end
      if (pull_req[i]) begin
        pull_valid[i] = (pcnt[i] >= plat);
        pull_data[i*DW +: DW] = {8'(i), 8'(widx[i]), 16'hC3A5};
        if (pull_valid[i]) widx[i]++;
        pcnt[i] = pull_valid[i] ? 0 : pcnt[i] + 1;
      end else begin
        pcnt[i] = 0;
        pull_valid[i] = (noise != 0) && !cyc[0];
        pull_data[i*DW +: DW] = 32'hDEAD0000 | 32'(cyc);
      end
    end
  end

  task automatic issue(input int f, input int b, input int gl, input int pl, input int nz);
    instr_fifo = SW'(f); instr_budget = CW'(b); instr_valid = 1;
    glat = gl; plat = pl; noise = nz;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin gcnt[i] = 0; pcnt[i] = 0; widx[i] = 0; end
    repeat (3) @(negedge clk);
    chk(instr_ready === 1'b1, "R1", "reset instr_ready", 64'(instr_ready), 64'd1);
    chk(conn_req === '0 && pull_req === '0 && rel === '0, "R1", "reset requests",
        64'({conn_req, pull_req, rel}), 64'd0);
    chk(out_valid === 1'b0 && done === 1'b0, "R1", "reset pulses", 64'({out_valid, done}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    issue(0, 1, 0, 0, 0);
    issue(2, 3, 2, 1, 1);
    issue(1, 0, 1, 0, 1);
    issue(3, 5, 0, 3, 1);
    issue(2, 2, 4, 0, 0);
    issue(0, 0, 0, 0, 0);
    issue(1, 1, 3, 2, 1);
    instr_valid = 0;
    while (!instr_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule